// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block supervises a processor by counting crystal clock cycles. A wide prescaler counts freely. Each time its low tap bits wrap, it advances a narrow watchdog counter. Software keeps the system alive by writing to one fixed bus address. That write is a service write and clears the watchdog counter. It also clears the upper part of the prescaler but leaves the low bits counting. If no service write arrives before the watchdog counter wraps, the block drives an active-low reset pulse of fixed length. It also sets a sticky cause flag.

A read of the same address returns the low byte of the reset vector, which is fed in from outside. Three events clear the prescaler: a one-shot power-on delay, an internal reset and a reset-vector fetch. The internal reset also clears the watchdog counter. While `por_n` is low, the whole block is idle.

Top module: `wdog_top`

## Requirements
- R1: The prescaler (PRE_W bits) counts every cycle. When its low TAP_W bits are all ones and it is not being cleared, the watchdog counter (WD_W bits) advances by one. If nothing clears either counter, the reset pulse begins 2^(TAP_W+WD_W) cycles after both counters were zero.
- R2: A service write is `bus_wr` high with `bus_addr` equal to SVC_ADDR (default 16'hFFFF). The write data is ignored. It clears the watchdog counter and prescaler bits CLR_LO and up, while bits below CLR_LO keep counting. The next pulse begins 2^(TAP_W+WD_W) − p cycles after the write edge, where p is the value kept in those low bits.
- R3: A write to any address other than SVC_ADDR has no effect on the timeout.
- R4: A watchdog reset holds `wdog_rst_n` low for exactly PULSE_LEN cycles (default 32).
- R5: `cause` goes high with the first low cycle of the pulse. It stays high until `cause_clr` is asserted or `por_n` goes low.
- R6: `rdata` equals `vec_lo` when `bus_rd` is high and `bus_addr` equals SVC_ADDR. Otherwise it is zero.
- R7: While `por_n` is low, `wdog_rst_n` is 1, `cause` is 0 and both counters are zero. After release, the prescaler is cleared once, POR_DLY cycles later (default 4096).
- R8: `int_rst` clears both counters. `vec_fetch` clears the prescaler only.
- R9: A service write in the same cycle as a watchdog overflow wins, and no pulse starts.
- R10: While the pulse is active, both counters are held at zero. A full timeout restarts on the edge where `wdog_rst_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| int_rst | input | 1 | Internal reset event, clears both counters |
| vec_fetch | input | 1 | Reset-vector fetch seen on the bus, clears prescaler |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| vec_lo | input | DATA_W | Low byte of the reset vector |
| cause_clr | input | 1 | Clears the sticky cause flag |
| rdata | output | DATA_W | Read data for the service address |
| wdog_rst_n | output | 1 | Watchdog reset pulse, active low |
| cause | output | 1 | Sticky watchdog-cause flag |

## Verification
A service write and a watchdog overflow can fall in the same cycle. The bench provokes this by issuing the write exactly one cycle before the pulse would start, counted from a known zero state. It judges the result by the reset line staying high at that edge. The next fall must come one full period later, which shows the write cleared the counters instead of merely masking a single pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        PCLR_NONE  = 2'd0,
        PCLR_UPPER = 2'd1,
        PCLR_ALL   = 2'd2
    } pclr_e;
endpackage

// File: rtl/wdog_por_timer.sv
module wdog_por_timer #(
    parameter int POR_DLY = 4096
) (
    input  logic clk,
    input  logic por_n,
    output logic fire_o
);
    localparam int CW = $clog2(POR_DLY + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (!st_q.done) begin
            if (st_q.cnt == CW'(POR_DLY - 1)) begin
                fire_o    = 1'b1;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // power-on clear is a single event
    assert_por_once_R7: assert property (@(posedge clk) disable iff (!por_n)
        fire_o |=> (!fire_o && st_q.done));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int PRE_W  = 13,
    parameter int TAP_W  = 12,
    parameter int CLR_LO = 4
) (
    input  logic  clk,
    input  logic  por_n,
    input  pclr_e clr_i,
    output logic  tap_o
);
    localparam logic [PRE_W-1:0] KEEP_MASK = PRE_W'((1 << CLR_LO) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [PRE_W-1:0] inc;

    always_comb begin
        inc   = st_q.cnt + 1'b1;
        st_d  = st_q;
        tap_o = 1'b0;
        case (clr_i)
            PCLR_ALL:   st_d.cnt = '0;
            PCLR_UPPER: st_d.cnt = inc & KEEP_MASK;
            default: begin
                st_d.cnt = inc;
                tap_o    = &st_q.cnt[TAP_W-1:0];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_upper_cleared_R2: assert property (@(posedge clk) disable iff (!por_n)
        (clr_i == PCLR_UPPER) |=> (st_q.cnt[PRE_W-1:CLR_LO] == '0));
    assert_low_kept_R2: assert property (@(posedge clk) disable iff (!por_n)
        (clr_i == PCLR_UPPER) |=>
        (st_q.cnt[CLR_LO-1:0] == CLR_LO'($past(st_q.cnt[CLR_LO-1:0]) + 1'b1)));
    assert_full_clear_R8: assert property (@(posedge clk) disable iff (!por_n)
        (clr_i == PCLR_ALL) |=> (st_q.cnt == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int WD_W = 6
) (
    input  logic clk,
    input  logic por_n,
    input  logic step_i,
    input  logic clr_i,
    output logic ovf_o
);
    typedef struct packed {
        logic [WD_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            ovf_o    = &st_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_clear_R8: assert property (@(posedge clk) disable iff (!por_n)
        clr_i |=> (st_q.cnt == '0));
    assert_step_R1: assert property (@(posedge clk) disable iff (!por_n)
        (step_i && !clr_i) |=> (st_q.cnt == WD_W'($past(st_q.cnt) + 1'b1)));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic trig_i,
    input  logic cause_clr_i,
    output logic active_o,
    output logic rst_n_o,
    output logic cause_o
);
    localparam int PCW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PCW-1:0] cnt;
        logic           cause;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i)               st_d.cnt = PCW'(PULSE_LEN);
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        if (trig_i)               st_d.cause = 1'b1;
        else if (cause_clr_i)     st_d.cause = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.cnt != '0);
    assign rst_n_o  = ~active_o;
    assign cause_o  = st_q.cause;

    // checker-only run length of the low phase
    logic [PCW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!por_n)        run_q <= '0;
        else if (!rst_n_o) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!por_n)
        trig_i |=> !rst_n_o);
    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> (run_q == PCW'(PULSE_LEN)));
    assert_cause_set_R5: assert property (@(posedge clk) disable iff (!por_n)
        trig_i |=> cause_o);
    assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!por_n)
        (cause_o && !cause_clr_i) |=> cause_o);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int              PRE_W     = 13,
    parameter int              TAP_W     = 12,
    parameter int              WD_W      = 6,
    parameter int              CLR_LO    = 4,
    parameter int              PULSE_LEN = 32,
    parameter int              POR_DLY   = 4096,
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 16'hFFFF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              int_rst,
    input  logic              vec_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] vec_lo,
    input  logic              cause_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              wdog_rst_n,
    output logic              cause
);
    logic  addr_hit, svc, por_fire, tap, ovf, active, wclr;
    pclr_e pclr;

    always_comb begin
        addr_hit = (bus_addr == SVC_ADDR);
        svc      = bus_wr && addr_hit;
        rdata    = (bus_rd && addr_hit) ? vec_lo : '0;
        if (int_rst || vec_fetch || por_fire || active) pclr = PCLR_ALL;
        else if (svc)                                   pclr = PCLR_UPPER;
        else                                            pclr = PCLR_NONE;
        wclr = int_rst || svc || active;
    end

    wdog_por_timer #(.POR_DLY(POR_DLY)) por_i (
        .clk(clk), .por_n(por_n), .fire_o(por_fire)
    );

    wdog_prescaler #(.PRE_W(PRE_W), .TAP_W(TAP_W), .CLR_LO(CLR_LO)) pre_i (
        .clk(clk), .por_n(por_n), .clr_i(pclr), .tap_o(tap)
    );

    wdog_counter #(.WD_W(WD_W)) cnt_i (
        .clk(clk), .por_n(por_n), .step_i(tap), .clr_i(wclr), .ovf_o(ovf)
    );

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) pls_i (
        .clk(clk), .por_n(por_n), .trig_i(ovf), .cause_clr_i(cause_clr),
        .active_o(active), .rst_n_o(wdog_rst_n), .cause_o(cause)
    );

    // a service write never lets a pulse start on the next edge
    assert_svc_wins_R9: assert property (@(posedge clk) disable iff (!por_n)
        (svc && wdog_rst_n) |=> wdog_rst_n);
    // while the pulse runs the prescaler never feeds the counter
    assert_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        !wdog_rst_n |-> !tap);
endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
    localparam int PERIOD_NS = 10;
    localparam int PRE_W = 7, TAP_W = 6, WD_W = 3, CLR_LO = 2;
    localparam int PULSE_LEN = 8, POR_DLY = 16;
    localparam int FULL = 1 << (TAP_W + WD_W);
    localparam int KEEP = 1 << CLR_LO;

    typedef struct packed {
        logic [15:0] a;
        logic        rd;
        logic [7:0]  v;
        logic [7:0]  e;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{a:16'hFFFF, rd:1'b1, v:8'hA5, e:8'hA5},
        '{a:16'hFFFF, rd:1'b0, v:8'hA5, e:8'h00},
        '{a:16'hFFFE, rd:1'b1, v:8'h3C, e:8'h00},
        '{a:16'h7FFF, rd:1'b1, v:8'h5A, e:8'h00},
        '{a:16'hFFFF, rd:1'b1, v:8'h00, e:8'h00},
        '{a:16'hFFFF, rd:1'b1, v:8'hFF, e:8'hFF}
    };

    logic clk = 1'b0;
    logic por_n = 1'b0, int_rst = 1'b0, vec_fetch = 1'b0;
    logic [15:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, cause_clr = 1'b0;
    logic [7:0] vec_lo = '0;
    logic [7:0] rdata;
    logic wdog_rst_n, cause;

    int n_chk = 0, n_fail = 0;

    always #(PERIOD_NS / 2) clk = ~clk;

    wdog_top #(.PRE_W(PRE_W), .TAP_W(TAP_W), .WD_W(WD_W), .CLR_LO(CLR_LO),
               .PULSE_LEN(PULSE_LEN), .POR_DLY(POR_DLY)) dut_i (
        .clk(clk), .por_n(por_n), .int_rst(int_rst), .vec_fetch(vec_fetch),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .vec_lo(vec_lo),
        .cause_clr(cause_clr), .rdata(rdata), .wdog_rst_n(wdog_rst_n), .cause(cause)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_until_fall(input int lim, output int n);
        n = 0;
        while (n < lim) begin
            step();
            n++;
            if (!wdog_rst_n) return;
        end
        n = -1;
    endtask

    task automatic wait_rise(output int low);
        low = 0;
        while (!wdog_rst_n) begin
            low++;
            step();
        end
    endtask

    // kind: 0 service write, 1 other-address write, 2 int_rst, 3 vec_fetch
    task automatic act_after(input int k, input int kind);
        repeat (k) step();
        case (kind)
            0: begin bus_addr = 16'hFFFF; bus_wr = 1'b1; end
            1: begin bus_addr = 16'hFFFE; bus_wr = 1'b1; end
            2: int_rst = 1'b1;
            default: vec_fetch = 1'b1;
        endcase
        step();
        bus_wr = 1'b0; int_rst = 1'b0; vec_fetch = 1'b0; bus_addr = '0;
    endtask

    task automatic timed(input int k, input int kind, input int exp, input string req);
        int n, low;
        act_after(k, kind);
        run_until_fall(4 * FULL, n);
        check((k + 1 + n) == exp, req, k + 1 + n, exp);
        wait_rise(low);
    endtask

    initial begin
        #(PERIOD_NS * 150000);
        n_fail++;
        $display("FAIL watchdog R1-timeout: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, low, k;
        bit seen_low;
        repeat (3) step();
        check(wdog_rst_n == 1'b1, "R7 reset rst_n", int'(wdog_rst_n), 1);
        check(cause == 1'b0, "R7 reset cause", int'(cause), 0);

        // R6: read path walked from the vector table
        foreach (TBL[i]) begin
            bus_addr = TBL[i].a; bus_rd = TBL[i].rd; vec_lo = TBL[i].v;
            #1;
            check(rdata == TBL[i].e, "R6 read", int'(rdata), int'(TBL[i].e));
        end
        bus_rd = 1'b0; bus_addr = '0;

        // R7 + R1: power-on clear delays the first timeout by POR_DLY
        por_n = 1'b1;
        run_until_fall(4 * FULL, n);
        check(n == POR_DLY + FULL, "R7 first timeout", n, POR_DLY + FULL);
        check(cause == 1'b1, "R5 cause on pulse", int'(cause), 1);
        wait_rise(low);
        check(low == PULSE_LEN, "R4 pulse length", low, PULSE_LEN);

        // R10 + R1: full period after the pulse
        run_until_fall(4 * FULL, n);
        check(n == FULL, "R10 restart period", n, FULL);
        wait_rise(low);

        // R2: service writes, low bits kept
        k = 5;
        timed(k, 0, k + 1 + FULL - ((k + 1) % KEEP), "R2 service k5");
        k = 10;
        timed(k, 0, k + 1 + FULL - ((k + 1) % KEEP), "R2 service k10");
        // R3: other address ignored
        timed(100, 1, FULL, "R3 other address");
        // R9: write in the overflow cycle
        timed(FULL - 1, 0, 2 * FULL, "R9 write on overflow");
        // R8: internal reset and vector fetch
        timed(300, 2, 301 + FULL, "R8 int_rst");
        timed(100, 3, 101 + FULL - (1 << TAP_W), "R8 vec_fetch");

        // R5: sticky, then cleared
        check(cause == 1'b1, "R5 cause sticky", int'(cause), 1);
        cause_clr = 1'b1; step(); cause_clr = 1'b0;
        check(cause == 1'b0, "R5 cause_clr", int'(cause), 0);

        // R2: periodic service keeps reset away
        seen_low = 1'b0;
        for (int j = 0; j < 6; j++) begin
            for (int c = 0; c < FULL / 2; c++) begin
                step();
                if (!wdog_rst_n) seen_low = 1'b1;
            end
            bus_addr = 16'hFFFF; bus_wr = 1'b1; step(); bus_wr = 1'b0; bus_addr = '0;
            if (!wdog_rst_n) seen_low = 1'b1;
        end
        check(!seen_low, "R2 periodic service", int'(seen_low), 0);
        check(cause == 1'b0, "R5 no new cause", int'(cause), 0);

        // R7: power-on clears cause and ends the pulse
        run_until_fall(4 * FULL, n);
        check(cause == 1'b1, "R5 cause again", int'(cause), 1);
        por_n = 1'b0; step();
        check(wdog_rst_n == 1'b1, "R7 por ends pulse", int'(wdog_rst_n), 1);
        check(cause == 1'b0, "R7 por clears cause", int'(cause), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule